// File: doc/BRIEF.md
# Multi-Round Interrupt Priority Arbiter

This block picks the highest priority number among a bank of interrupt requests and publishes it to a processor core. Each request line brings a request bit, an enable bit and an 8-bit priority number. Priority 0 means "no request". The winning number is found in 2-bit slices, most significant slice first, one slice for each interrupt-bus cycle. A round narrows the candidate set to the requests whose slice equals the largest slice present. The search ends as soon as one candidate is left, or after four rounds.

The prefix built up while the search runs stays in an internal working register. The visible pending priority field changes only when a finished result is committed, and then together with a separate request flag. The flag tells the core that the field holds a valid number. An acknowledge pulse in the core clock domain clears both at once.

The interrupt bus can run at half the core rate. This is modelled by a bus-cycle strobe: the search advances only on strobed cycles, but the acknowledge is honoured on every core cycle. The block moves no data stream, so it has no valid/ready handshake. All of its pins are plain control and status levels, sampled on every clock edge.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A request line takes part only when its request bit is 1, its enable bit is 1 and its priority number is non-zero. Other lines never influence the result.
- R2: A committed result equals the largest priority number among the lines that took part, as sampled on the bus cycle that started the search. Ties give that shared number.
- R3: A search takes one bus cycle to sample, then one bus cycle per round. Round k (k = 0..3) compares priority bits [7-2k:6-2k]. The search commits in the round that leaves a single candidate, or in round 3. With the strobe held high, a single candidate appears on the output 2 cycles after it is applied, and a search that needs all four rounds takes 5 cycles.
- R4: The pending field reads 0 whenever the request flag is low. Whenever the flag is high, the field is non-zero.
- R5: No partial prefix ever appears on the pending field. For example, with 0x81 and 0x80 pending, 0x80 is never shown; only 0x81 is.
- R6: An acknowledge pulse clears the flag and the field on the next clock edge. This holds on any core cycle, whether or not the strobe is high.
- R7: A search that is running when an acknowledge arrives, or that would finish in that same cycle, is discarded. A new search starts on a later bus cycle.
- R8: While the flag is set and no acknowledge has come, each finished search replaces the field. A higher request that arrives later therefore takes over the field.
- R9: On cycles with the strobe low and no acknowledge, the flag and the field hold their values. With the strobe toggling (2:1 mode), results still match R2.
- R10: After reset the flag is 0 and the field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Strobe marking interrupt-bus cycles; held high for 1:1 mode |
| irq_req | input | NUM_REQ | Request bit per line |
| irq_en | input | NUM_REQ | Enable bit per line |
| irq_prio | input | NUM_REQ*PRIO_W | Priority numbers; line i occupies bits [i*PRIO_W +: PRIO_W] |
| ack | input | 1 | Single-cycle acknowledge from the core |
| irq_flag | output | 1 | Request flag: the field holds a valid number |
| pend_prio | output | PRIO_W | Visible pending priority number |

## Verification
A wrong round filter or a stale working prefix shows up as a wrong committed number on the pending field. A bad commit gate shows up as a partial value such as 0x80 appearing in place of 0x81. The field is watched on every cycle, so either fault is caught on the cycle it is published. A lost acknowledge shows up as a flag that is still set one cycle after the pulse, and a search that is not discarded shows up as a commit arriving a few bus cycles after the requests were withdrawn. Commit latency in 1:1 mode is also counted, so an extra or missing round shows up as a flag rising a cycle early or late.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_RUN  = 1'b1
  } arb_state_e;
endpackage

// File: rtl/irq_req_qualify.sv
// Marks the lines that may enter a search: request and enable set, number non-zero.
module irq_req_qualify #(
  parameter int NUM_REQ = 8,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_REQ-1:0]        req,
  input  logic [NUM_REQ-1:0]        en,
  input  logic [NUM_REQ*PRIO_W-1:0] prio,
  output logic [NUM_REQ-1:0]        elig
);
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_line
    assign elig[i] = req[i] & en[i] & (|prio[i*PRIO_W +: PRIO_W]);
  end
endmodule

// File: rtl/irq_slice_pick.sv
// One arbitration round: take the largest slice among candidates and keep the matches.
module irq_slice_pick #(
  parameter int NUM_REQ = 8,
  parameter int PRIO_W  = 8,
  parameter int SLICE_W = 2,
  parameter int RND_W   = 2
) (
  input  logic [NUM_REQ-1:0]        cand,
  input  logic [NUM_REQ*PRIO_W-1:0] prio,
  input  logic [RND_W-1:0]          rnd,
  output logic [SLICE_W-1:0]        slice_max,
  output logic [NUM_REQ-1:0]        surv,
  output logic                      surv_single,
  output logic [PRIO_W-1:0]         surv_or
);
  localparam int ROUNDS = PRIO_W / SLICE_W;

  logic [SLICE_W-1:0] slice_v [NUM_REQ];
  int                 shamt;

  assign shamt = (ROUNDS - 1 - int'(rnd)) * SLICE_W;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_slice
    logic [PRIO_W-1:0] p_i;
    assign p_i        = prio[i*PRIO_W +: PRIO_W];
    assign slice_v[i] = SLICE_W'(p_i >> shamt);
    assign surv[i]    = cand[i] && (slice_v[i] == slice_max);
  end

  always_comb begin
    slice_max = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (cand[i] && (slice_v[i] > slice_max)) slice_max = slice_v[i];
    end
  end

  always_comb begin
    surv_or = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (surv[i]) surv_or = surv_or | prio[i*PRIO_W +: PRIO_W];
    end
  end

  assign surv_single = $onehot(surv);
endmodule

// File: rtl/irq_arb_ctrl.sv
// Round sequencing, snapshot, working prefix, commit and acknowledge handling.
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int PRIO_W  = 8,
  parameter int SLICE_W = 2,
  parameter int RND_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_en,
  input  logic                      ack,
  input  logic [NUM_REQ-1:0]        elig,
  input  logic [NUM_REQ*PRIO_W-1:0] prio_in,
  input  logic [SLICE_W-1:0]        slice_max,
  input  logic [NUM_REQ-1:0]        surv,
  input  logic                      surv_single,
  input  logic [PRIO_W-1:0]         surv_or,
  output logic [NUM_REQ-1:0]        cand,
  output logic [NUM_REQ*PRIO_W-1:0] snap_prio,
  output logic [RND_W-1:0]          rnd,
  output logic                      irq_flag,
  output logic [PRIO_W-1:0]         pend_prio
);
  localparam int ROUNDS = PRIO_W / SLICE_W;

  arb_state_e  state_q;
  logic [PRIO_W-1:0] prefix_q, prefix_nxt, commit_val;
  logic        ack_seen_q;
  logic        last_rnd, finish, drop_result;

  assign prefix_nxt  = {prefix_q[PRIO_W-SLICE_W-1:0], slice_max};
  assign last_rnd    = (rnd == RND_W'(ROUNDS - 1));
  assign finish      = surv_single || last_rnd;
  assign commit_val  = surv_single ? surv_or : prefix_nxt;
  assign drop_result = ack || ack_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ARB_IDLE;
      cand       <= '0;
      snap_prio  <= '0;
      rnd        <= '0;
      prefix_q   <= '0;
      ack_seen_q <= 1'b0;
      irq_flag   <= 1'b0;
      pend_prio  <= '0;
    end else begin
      if (ack) begin
        irq_flag  <= 1'b0;
        pend_prio <= '0;
      end
      unique case (state_q)
        ARB_IDLE: begin
          if (bus_en && (|elig)) begin
            snap_prio  <= prio_in;
            cand       <= elig;
            rnd        <= '0;
            prefix_q   <= '0;
            ack_seen_q <= ack;
            state_q    <= ARB_RUN;
          end
        end
        ARB_RUN: begin
          if (ack) ack_seen_q <= 1'b1;
          if (bus_en) begin
            cand     <= surv;
            prefix_q <= prefix_nxt;
            rnd      <= rnd + 1'b1;
            if (finish) begin
              state_q <= ARB_IDLE;
              if (!drop_result) begin
                irq_flag  <= 1'b1;
                pend_prio <= commit_val;
              end
            end
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NUM_REQ = 8,
  parameter int PRIO_W  = 8,
  parameter int SLICE_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_en,
  input  logic [NUM_REQ-1:0]        irq_req,
  input  logic [NUM_REQ-1:0]        irq_en,
  input  logic [NUM_REQ*PRIO_W-1:0] irq_prio,
  input  logic                      ack,
  output logic                      irq_flag,
  output logic [PRIO_W-1:0]         pend_prio
);
  localparam int ROUNDS = PRIO_W / SLICE_W;
  localparam int RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  logic [NUM_REQ-1:0]        elig, cand, surv;
  logic [NUM_REQ*PRIO_W-1:0] snap_prio;
  logic [RND_W-1:0]          rnd;
  logic [SLICE_W-1:0]        slice_max;
  logic                      surv_single;
  logic [PRIO_W-1:0]         surv_or;

  irq_req_qualify #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) i_qual (
    .req (irq_req),
    .en  (irq_en),
    .prio(irq_prio),
    .elig(elig)
  );

  irq_slice_pick #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W), .SLICE_W(SLICE_W), .RND_W(RND_W)) i_pick (
    .cand       (cand),
    .prio       (snap_prio),
    .rnd        (rnd),
    .slice_max  (slice_max),
    .surv       (surv),
    .surv_single(surv_single),
    .surv_or    (surv_or)
  );

  irq_arb_ctrl #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W), .SLICE_W(SLICE_W), .RND_W(RND_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .ack        (ack),
    .elig       (elig),
    .prio_in    (irq_prio),
    .slice_max  (slice_max),
    .surv       (surv),
    .surv_single(surv_single),
    .surv_or    (surv_or),
    .cand       (cand),
    .snap_prio  (snap_prio),
    .rnd        (rnd),
    .irq_flag   (irq_flag),
    .pend_prio  (pend_prio)
  );
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              ack,
  input logic              irq_flag,
  input logic [PRIO_W-1:0] pend_prio
);
  // R4: field is zero while the flag is low
  assert_field_zero_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag |-> (pend_prio == '0));

  // R4: a raised flag always comes with a usable number
  assert_flag_has_number_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag |-> (pend_prio != '0));

  // R6: acknowledge clears on the next edge
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!irq_flag && (pend_prio == '0)));

  // R9: nothing moves between bus strobes unless acknowledged
  assert_hold_off_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en && !ack) |=> ($stable(pend_prio) && $stable(irq_flag)));

  // R5: a new value on the field is only published on a strobed cycle
  assert_publish_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !bus_en) |=> !$rose(irq_flag));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.PRIO_W(PRIO_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .ack      (ack),
  .irq_flag (irq_flag),
  .pend_prio(pend_prio)
);

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
  localparam int NUM_REQ = 8;
  localparam int PRIO_W  = 8;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      bus_en = 1'b1;
  logic                      div2 = 1'b0;
  logic [NUM_REQ-1:0]        irq_req = '0;
  logic [NUM_REQ-1:0]        irq_en = '0;
  logic [NUM_REQ*PRIO_W-1:0] irq_prio = '0;
  logic                      ack = 1'b0;
  logic                      irq_flag;
  logic [PRIO_W-1:0]         pend_prio;

  int checks = 0;
  int errors = 0;
  logic [PRIO_W-1:0] exp_q [$];
  logic [PRIO_W-1:0] last_pend = '0;

  irq_prio_arbiter #(.NUM_REQ(NUM_REQ), .PRIO_W(PRIO_W)) i_irq_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .irq_req(irq_req), .irq_en(irq_en),
    .irq_prio(irq_prio), .ack(ack), .irq_flag(irq_flag), .pend_prio(pend_prio)
  );

  always #5 clk = ~clk;

  // bus strobe changes shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      bus_en = div2 ? ~bus_en : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: every newly published non-zero value must match the next expected item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (pend_prio != last_pend) && (pend_prio != '0)) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected publish", int'(pend_prio), 0);
        else begin
          logic [PRIO_W-1:0] e;
          e = exp_q.pop_front();
          chk(pend_prio == e, "R2/R5 published value", int'(pend_prio), int'(e));
        end
      end
      last_pend = pend_prio;
    end
  end

  task automatic set_line(input int idx, input logic [PRIO_W-1:0] p, input logic e);
    irq_req[idx] = 1'b1;
    irq_en[idx]  = e;
    irq_prio[idx*PRIO_W +: PRIO_W] = p;
  endtask

  task automatic clear_lines();
    irq_req = '0; irq_en = '0; irq_prio = '0;
  endtask

  // driver: push expected result, wait for flag, report latency
  task automatic drive_case(input logic [PRIO_W-1:0] exp, input int exp_lat,
                            input string tag, output int lat);
    exp_q.push_back(exp);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!irq_flag && lat < 60);
    chk(irq_flag == 1'b1, {tag, " flag raised"}, int'(irq_flag), 1);
    if (exp_lat > 0) chk(lat == exp_lat, {tag, " R3 latency"}, lat, exp_lat);
  endtask

  task automatic do_ack(input string tag);
    ack = 1'b1;
    clear_lines();
    @(negedge clk);
    ack = 1'b0;
    chk(!irq_flag && pend_prio == '0, {tag, " R6 ack clears"}, int'(pend_prio), 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(irq_flag == 1'b0, "R10 flag after reset", int'(irq_flag), 0);
    chk(pend_prio == '0, "R10 field after reset", int'(pend_prio), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 single candidate: 1 round
    set_line(2, 8'hC3, 1'b1);
    drive_case(8'hC3, 2, "R3 single", lat);
    @(negedge clk);
    do_ack("single");

    // R5: 0x81 vs 0x80 vs 0x20, four rounds, no 0x80 seen
    set_line(0, 8'h81, 1'b1); set_line(5, 8'h80, 1'b1); set_line(7, 8'h20, 1'b1);
    drive_case(8'h81, 5, "R5 prefix", lat);
    do_ack("prefix");

    // R1: disabled line and zero-number line ignored
    set_line(0, 8'hFF, 1'b0); set_line(1, 8'h00, 1'b1); set_line(4, 8'h10, 1'b1);
    drive_case(8'h10, 2, "R1 eligibility", lat);
    do_ack("elig");

    // R2 tie: shared number after all rounds
    set_line(3, 8'h55, 1'b1); set_line(6, 8'h55, 1'b1);
    drive_case(8'h55, 5, "R2 tie", lat);
    do_ack("tie");

    // R1: only a zero-number request -> never flagged
    set_line(1, 8'h00, 1'b1);
    repeat (12) @(negedge clk);
    chk(!irq_flag && pend_prio == '0, "R1 zero number ignored", int'(pend_prio), 0);
    clear_lines();
    repeat (4) @(negedge clk);

    // R8: higher request replaces an unacknowledged result
    set_line(1, 8'h20, 1'b1);
    drive_case(8'h20, 2, "R8 first", lat);
    set_line(3, 8'h90, 1'b1);
    exp_q.push_back(8'h90);
    lat = 0;
    do begin @(negedge clk); lat++; end while (pend_prio != 8'h90 && lat < 40);
    chk(pend_prio == 8'h90, "R8 replaced value", int'(pend_prio), 8'h90);
    do_ack("replace");

    // R7: acknowledge mid-search discards it
    set_line(0, 8'h40, 1'b1); set_line(1, 8'h41, 1'b1);
    @(negedge clk);
    @(negedge clk);
    do_ack("discard");
    repeat (4) @(negedge clk);
    chk(!irq_flag && pend_prio == '0, "R7 discarded search", int'(pend_prio), 0);

    // R9: 2:1 mode
    div2 = 1'b1;
    repeat (4) @(negedge clk);
    set_line(2, 8'h81, 1'b1); set_line(6, 8'h7F, 1'b1);
    drive_case(8'h81, 0, "R9 half rate", lat);
    chk(lat >= 3, "R9 slower in 2:1", lat, 3);
    while (bus_en) @(negedge clk);
    do_ack("R9 ack off strobe");
    div2 = 1'b0;
    repeat (4) @(negedge clk);

    chk(exp_q.size() == 0, "R2 all results published", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule